// File: doc/BRIEF.md
# Banked Vector Memory Issue Controller

This block sits between several vector access streams and a set of interleaved memory banks. Each source presents one request per cycle: an address and a tag. The low-order residue of the address, taken modulo the bank count, selects a bank. A bank that starts an access stays occupied for a fixed number of processor cycles. When the bank of the access completes, the block reports the source number and the tag on that bank's response lane, so a source can match answers that come back out of order.

A request whose bank is occupied does not stall the stream. It moves into a small wait buffer, and later requests to idle banks go past it. Each cycle the buffer releases its oldest entry whose bank has become idle, and only then are new requests considered. Once the buffer is full, a request that cannot start at once is held off with backpressure. Strides that share a factor with the bank count pile many requests onto a few banks, and that raises the buffer occupancy. For this reason the bank count is a free parameter: it may be a power of two or a nearby odd count such as 2^k+1.

Top module: `vec_bank_mem`

## Requirements
- R1: The bank of a request is its address modulo NBANK. Its response appears on the rsp lane with that index.
- R2: A request that starts at once in cycle t is accepted in that cycle (req_ready high). In cycle t+BUSY-1, rsp_valid of its bank is high for exactly one cycle, carrying the request's source index and tag.
- R3: A bank that starts an access in cycle t starts no other access before cycle t+BUSY. It may start the next one in cycle t+BUSY.
- R4: A valid request that cannot start is accepted into the wait buffer while the buffer has room.
- R5: A request to an idle bank starts at once even when earlier requests to other banks are still waiting.
- R6: At most one buffered entry starts per cycle. It is the oldest entry whose bank is idle, and it takes its bank ahead of any new request in the same cycle.
- R7: A new request to a bank that already has a buffered entry is itself buffered, so accesses to one bank start in arrival order.
- R8: When several new requests compete in one cycle, the lower source index claims a bank first and is also placed in the buffer first.
- R9: A valid request that cannot start and finds the buffer full (counting the entry that leaves this cycle) sees req_ready low and is not taken.
- R10: After reset all rsp_valid lanes are low and the wait buffer is empty.
- R11: Elaboration rejects a buffer depth that is not a power of two, a BUSY below 2, or fewer than 2 banks or sources.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Processor clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | NSRC | Request present, one bit per source |
| req_addr | input | NSRC*AW | Request address, AW bits per source |
| req_tag | input | NSRC*TW | Request tag, TW bits per source |
| req_ready | output | NSRC | Request taken this cycle (started or buffered) |
| rsp_valid | output | NBANK | Access on this bank completes this cycle |
| rsp_src | output | NBANK*idx_w(NSRC) | Source index of the completing access |
| rsp_tag | output | NBANK*TW | Tag of the completing access |

## Verification
The bench builds the block with NBANK=5, DEPTH=4, BUSY=6 and two sources. The odd bank count selects the modulo mapping variant, and strides of 5 and 10 then put every access of a stream on a single bank. A four-entry buffer fills within three cycles, so backpressure and release from a full buffer come up both in the directed cases and in the strided random traffic. The default power-of-two build uses the bit-slice variant, which shares the rest of the datapath.

// File: rtl/vbm_pkg.sv
package vbm_pkg;
   // index width that never collapses to zero
   function automatic int idx_w(input int n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction

   function automatic bit is_pow2(input int n);
      return (n > 0) && ((n & (n - 1)) == 0);
   endfunction
endpackage

// File: rtl/vbm_bank_map.sv
module vbm_bank_map import vbm_pkg::*; #(
   parameter int AW    = 16,
   parameter int NBANK = 16,
   parameter int BW    = idx_w(NBANK)
) (
   input  logic [AW-1:0] addr,
   output logic [BW-1:0] bank
);
   generate
      if (is_pow2(NBANK)) begin : g_slice
         // power-of-two bank count: the residue is the low bits
         logic unused_hi;
         assign unused_hi = ^addr[AW-1:BW];
         assign bank = addr[BW-1:0];
      end else begin : g_mod
         // odd bank counts spread strides that share factors with 2^k
         logic [AW-1:0] rem;
         logic          unused_rem;
         assign rem        = addr % AW'(NBANK);
         assign unused_rem = ^rem[AW-1:BW];
         assign bank       = rem[BW-1:0];
      end
   endgenerate
endmodule

// File: rtl/vbm_bank_slot.sv
module vbm_bank_slot import vbm_pkg::*; #(
   parameter int NSRC = 2,
   parameter int TW   = 4,
   parameter int BUSY = 6,
   parameter int SW   = idx_w(NSRC),
   parameter int CW   = idx_w(BUSY)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          go,
   input  logic [SW-1:0] go_src,
   input  logic [TW-1:0] go_tag,
   output logic          idle,
   output logic          rsp_valid,
   output logic [SW-1:0] rsp_src,
   output logic [TW-1:0] rsp_tag
);
   logic [CW-1:0] left_q;
   logic [SW-1:0] src_q;
   logic [TW-1:0] tag_q;

   // left_q counts the busy cycles after the start cycle
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         left_q <= '0;
         src_q  <= '0;
         tag_q  <= '0;
      end else if (go) begin
         left_q <= CW'(BUSY - 1);
         src_q  <= go_src;
         tag_q  <= go_tag;
      end else if (left_q != '0) begin
         left_q <= left_q - 1'b1;
      end
   end

   assign idle      = (left_q == '0);
   assign rsp_valid = (left_q == CW'(1));
   assign rsp_src   = src_q;
   assign rsp_tag   = tag_q;

   // R3: the issue logic never starts an occupied bank
   assert_go_when_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
      go |-> idle);
   // R2: a completion is a single-cycle pulse
   assert_rsp_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |=> !rsp_valid);
endmodule

// File: rtl/vbm_wait_buffer.sv
module vbm_wait_buffer import vbm_pkg::*; #(
   parameter int DEPTH = 8,
   parameter int NSRC  = 2,
   parameter int TW    = 4,
   parameter int BW    = 4,
   parameter int SW    = idx_w(NSRC),
   parameter int IW    = idx_w(DEPTH),
   parameter int CNTW  = $clog2(DEPTH + 1)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                pick_vld,
   input  logic [IW-1:0]       pick_idx,
   input  logic [NSRC-1:0]     enq,
   input  logic [NSRC*BW-1:0]  new_bank,
   input  logic [NSRC*TW-1:0]  new_tag,
   output logic [DEPTH-1:0]    ent_vld,
   output logic [DEPTH*BW-1:0] ent_bank,
   output logic [DEPTH*SW-1:0] ent_src,
   output logic [DEPTH*TW-1:0] ent_tag,
   output logic [CNTW-1:0]     ent_count
);
   // entries stay packed from slot 0 (oldest) upward
   logic [BW-1:0]   bank_q [DEPTH];
   logic [SW-1:0]   src_q  [DEPTH];
   logic [TW-1:0]   tag_q  [DEPTH];
   logic [CNTW-1:0] count_q;

   logic [BW-1:0]   bank_d [DEPTH];
   logic [SW-1:0]   src_d  [DEPTH];
   logic [TW-1:0]   tag_d  [DEPTH];
   logic [CNTW-1:0] count_d;

   always_comb begin
      int j;
      bank_d = bank_q;
      src_d  = src_q;
      tag_d  = tag_q;
      j      = 0;
      // close the gap left by the released entry
      for (int i = 0; i < DEPTH; i++) begin
         if (i < int'(count_q) && !(pick_vld && int'(pick_idx) == i)) begin
            bank_d[IW'(j)] = bank_q[i];
            src_d[IW'(j)]  = src_q[i];
            tag_d[IW'(j)]  = tag_q[i];
            j++;
         end
      end
      // append newcomers, lowest source first
      for (int s = 0; s < NSRC; s++) begin
         if (enq[s] && j < DEPTH) begin
            bank_d[IW'(j)] = new_bank[s*BW +: BW];
            src_d[IW'(j)]  = SW'(s);
            tag_d[IW'(j)]  = new_tag[s*TW +: TW];
            j++;
         end
      end
      count_d = CNTW'(j);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         count_q <= '0;
      end else begin
         count_q <= count_d;
         bank_q  <= bank_d;
         src_q   <= src_d;
         tag_q   <= tag_d;
      end
   end

   generate
      for (genvar i = 0; i < DEPTH; i++) begin : g_out
         assign ent_vld[i]              = (CNTW'(i) < count_q);
         assign ent_bank[i*BW +: BW]    = bank_q[i];
         assign ent_src[i*SW +: SW]     = src_q[i];
         assign ent_tag[i*TW +: TW]     = tag_q[i];
      end
   endgenerate
   assign ent_count = count_q;

   // R9: nothing is written into a full buffer that frees no slot
   assert_no_overflow_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (count_q == CNTW'(DEPTH) && !pick_vld) |-> (enq == '0));
   // R6: a release always names a live entry
   assert_pick_live_R6: assert property (@(posedge clk) disable iff (!rst_n)
      pick_vld |-> (CNTW'(pick_idx) < count_q));
endmodule

// File: rtl/vbm_issue_ctrl.sv
module vbm_issue_ctrl import vbm_pkg::*; #(
   parameter int NSRC  = 2,
   parameter int NBANK = 16,
   parameter int DEPTH = 8,
   parameter int TW    = 4,
   parameter int BW    = idx_w(NBANK),
   parameter int SW    = idx_w(NSRC),
   parameter int IW    = idx_w(DEPTH),
   parameter int CNTW  = $clog2(DEPTH + 1)
) (
   input  logic [NBANK-1:0]    bank_idle,
   input  logic [DEPTH-1:0]    ent_vld,
   input  logic [DEPTH*BW-1:0] ent_bank,
   input  logic [DEPTH*SW-1:0] ent_src,
   input  logic [DEPTH*TW-1:0] ent_tag,
   input  logic [CNTW-1:0]     ent_count,
   input  logic [NSRC-1:0]     req_valid,
   input  logic [NSRC*BW-1:0]  req_bank,
   input  logic [NSRC*TW-1:0]  req_tag,
   output logic                pick_vld,
   output logic [IW-1:0]       pick_idx,
   output logic [NSRC-1:0]     enq,
   output logic [NSRC-1:0]     req_ready,
   output logic [NBANK-1:0]    bank_go,
   output logic [NBANK*SW-1:0] go_src,
   output logic [NBANK*TW-1:0] go_tag
);
   always_comb begin
      logic [NBANK-1:0] pending;
      logic [NBANK-1:0] claimed;
      logic [BW-1:0]    b;
      int               occ;
      pending   = '0;
      claimed   = '0;
      b         = '0;
      occ       = 0;
      pick_vld  = 1'b0;
      pick_idx  = '0;
      enq       = '0;
      req_ready = '0;
      bank_go   = '0;
      go_src    = '0;
      go_tag    = '0;

      // banks that still owe an access to a waiting entry
      for (int i = 0; i < DEPTH; i++)
         if (ent_vld[i]) pending[ent_bank[i*BW +: BW]] = 1'b1;

      // oldest waiting entry whose bank has come free
      for (int i = 0; i < DEPTH; i++) begin
         b = ent_bank[i*BW +: BW];
         if (!pick_vld && ent_vld[i] && bank_idle[b]) begin
            pick_vld                 = 1'b1;
            pick_idx                 = IW'(i);
            claimed[b]               = 1'b1;
            bank_go[b]               = 1'b1;
            go_src[int'(b)*SW +: SW] = ent_src[i*SW +: SW];
            go_tag[int'(b)*TW +: TW] = ent_tag[i*TW +: TW];
         end
      end

      occ = int'(ent_count) - (pick_vld ? 1 : 0);

      // new requests in source order: start, else wait, else hold off
      for (int s = 0; s < NSRC; s++) begin
         if (req_valid[s]) begin
            b = req_bank[s*BW +: BW];
            if (bank_idle[b] && !claimed[b] && !pending[b]) begin
               claimed[b]               = 1'b1;
               bank_go[b]               = 1'b1;
               go_src[int'(b)*SW +: SW] = SW'(s);
               go_tag[int'(b)*TW +: TW] = req_tag[s*TW +: TW];
               req_ready[s]             = 1'b1;
            end else if (occ < DEPTH) begin
               enq[s]       = 1'b1;
               req_ready[s] = 1'b1;
               occ++;
            end
         end
      end
   end
endmodule

// File: rtl/vec_bank_mem.sv
module vec_bank_mem import vbm_pkg::*; #(
   parameter int NSRC  = 2,
   parameter int NBANK = 16,
   parameter int BUSY  = 6,
   parameter int DEPTH = 8,
   parameter int AW    = 16,
   parameter int TW    = 4
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic [NSRC-1:0]               req_valid,
   input  logic [NSRC*AW-1:0]            req_addr,
   input  logic [NSRC*TW-1:0]            req_tag,
   output logic [NSRC-1:0]               req_ready,
   output logic [NBANK-1:0]              rsp_valid,
   output logic [NBANK*idx_w(NSRC)-1:0]  rsp_src,
   output logic [NBANK*TW-1:0]           rsp_tag
);
   localparam int BW   = idx_w(NBANK);
   localparam int SW   = idx_w(NSRC);
   localparam int IW   = idx_w(DEPTH);
   localparam int CNTW = $clog2(DEPTH + 1);

   // R11: parameter sanity at elaboration
   generate
      if (!is_pow2(DEPTH)) begin : g_bad_depth
         $error("wait buffer depth must be a power of two");
      end
      if (BUSY < 2) begin : g_bad_busy
         $error("bank occupancy must be at least two cycles");
      end
      if (NBANK < 2 || NSRC < 2) begin : g_bad_count
         $error("need at least two banks and two sources");
      end
      if (AW <= BW) begin : g_bad_aw
         $error("address must be wider than the bank index");
      end
   endgenerate

   logic [NSRC*BW-1:0]  req_bank;
   logic [NBANK-1:0]    bank_idle;
   logic [NBANK-1:0]    bank_go;
   logic [NBANK*SW-1:0] go_src;
   logic [NBANK*TW-1:0] go_tag;
   logic [DEPTH-1:0]    ent_vld;
   logic [DEPTH*BW-1:0] ent_bank;
   logic [DEPTH*SW-1:0] ent_src;
   logic [DEPTH*TW-1:0] ent_tag;
   logic [CNTW-1:0]     buf_count;
   logic                pick_vld;
   logic [IW-1:0]       pick_idx;
   logic [NSRC-1:0]     enq;

   generate
      for (genvar s = 0; s < NSRC; s++) begin : g_map
         vbm_bank_map #(.AW(AW), .NBANK(NBANK), .BW(BW)) u_map (
            .addr (req_addr[s*AW +: AW]),
            .bank (req_bank[s*BW +: BW])
         );
      end
      for (genvar k = 0; k < NBANK; k++) begin : g_bank
         vbm_bank_slot #(.NSRC(NSRC), .TW(TW), .BUSY(BUSY), .SW(SW)) u_slot (
            .clk       (clk),
            .rst_n     (rst_n),
            .go        (bank_go[k]),
            .go_src    (go_src[k*SW +: SW]),
            .go_tag    (go_tag[k*TW +: TW]),
            .idle      (bank_idle[k]),
            .rsp_valid (rsp_valid[k]),
            .rsp_src   (rsp_src[k*SW +: SW]),
            .rsp_tag   (rsp_tag[k*TW +: TW])
         );
      end
   endgenerate

   vbm_wait_buffer #(.DEPTH(DEPTH), .NSRC(NSRC), .TW(TW), .BW(BW),
                     .SW(SW), .IW(IW), .CNTW(CNTW)) u_wait (
      .clk       (clk),
      .rst_n     (rst_n),
      .pick_vld  (pick_vld),
      .pick_idx  (pick_idx),
      .enq       (enq),
      .new_bank  (req_bank),
      .new_tag   (req_tag),
      .ent_vld   (ent_vld),
      .ent_bank  (ent_bank),
      .ent_src   (ent_src),
      .ent_tag   (ent_tag),
      .ent_count (buf_count)
   );

   vbm_issue_ctrl #(.NSRC(NSRC), .NBANK(NBANK), .DEPTH(DEPTH), .TW(TW),
                    .BW(BW), .SW(SW), .IW(IW), .CNTW(CNTW)) u_issue (
      .bank_idle (bank_idle),
      .ent_vld   (ent_vld),
      .ent_bank  (ent_bank),
      .ent_src   (ent_src),
      .ent_tag   (ent_tag),
      .ent_count (buf_count),
      .req_valid (req_valid),
      .req_bank  (req_bank),
      .req_tag   (req_tag),
      .pick_vld  (pick_vld),
      .pick_idx  (pick_idx),
      .enq       (enq),
      .req_ready (req_ready),
      .bank_go   (bank_go),
      .go_src    (go_src),
      .go_tag    (go_tag)
   );

   generate
      for (genvar s = 0; s < NSRC; s++) begin : g_chk
         // R9: a source is held off only when the buffer ends the cycle full
         assert_stall_only_full_R9: assert property (@(posedge clk) disable iff (!rst_n)
            (req_valid[s] && !req_ready[s]) |=> (buf_count == CNTW'(DEPTH)));
      end
   endgenerate
endmodule

// File: tb/sim_vec_bank_mem.sv
`timescale 1ns/1ps
module sim_vec_bank_mem;
   localparam int NSRC = 2, NB = 5, BUSY = 6, DEPTH = 4, AW = 12, TW = 4;

   logic               clk = 1'b0;
   logic               rst_n = 1'b0;
   logic [NSRC-1:0]    req_valid = '0;
   logic [NSRC*AW-1:0] req_addr = '0;
   logic [NSRC*TW-1:0] req_tag = '0;
   logic [NSRC-1:0]    req_ready;
   logic [NB-1:0]      rsp_valid;
   logic [NB-1:0]      rsp_src;
   logic [NB*TW-1:0]   rsp_tag;

   int nchk = 0, nfail = 0;

   always #10 clk = ~clk;

   vec_bank_mem #(.NSRC(NSRC), .NBANK(NB), .BUSY(BUSY), .DEPTH(DEPTH),
                  .AW(AW), .TW(TW)) u0 (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
      .req_tag(req_tag), .req_ready(req_ready), .rsp_valid(rsp_valid),
      .rsp_src(rsp_src), .rsp_tag(rsp_tag));

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      nchk++;
      if (!ok) begin
         nfail++;
         $display("FAIL %s actual=%0d expected=%0d (t=%0t)", req, act, exp, $time);
      end
   endtask

   // ---------------- reference model, evaluated mid-cycle ----------------
   typedef struct { int src; int tag; int bank; } went_t;
   went_t q[$];
   int    start_cyc [NB];
   int    s_src [NB];
   int    s_tag [NB];
   int    cyc;
   bit    acc [NSRC];

   function automatic bit m_idle(int b);
      return cyc >= start_cyc[b] + BUSY;
   endfunction

   always @(negedge clk) begin
      if (!rst_n) begin
         q.delete();
         for (int b = 0; b < NB; b++) start_cyc[b] = -1000;
         cyc = 0;
         for (int s = 0; s < NSRC; s++) acc[s] = 0;
      end else begin
         bit claimed [NB];
         bit pending [NB];
         bit issue [NSRC];
         bit put [NSRC];
         bit rdy [NSRC];
         int pick, occ, bk;
         pick = -1;
         for (int b = 0; b < NB; b++) begin claimed[b] = 0; pending[b] = 0; end
         foreach (q[i]) pending[q[i].bank] = 1;
         foreach (q[i]) if (pick < 0 && m_idle(q[i].bank)) pick = i;
         if (pick >= 0) claimed[q[pick].bank] = 1;
         occ = q.size() - ((pick >= 0) ? 1 : 0);
         for (int s = 0; s < NSRC; s++) begin
            issue[s] = 0; put[s] = 0; rdy[s] = 0;
            if (req_valid[s]) begin
               bk = int'(req_addr[s*AW +: AW]) % NB;
               if (m_idle(bk) && !claimed[bk] && !pending[bk]) begin
                  issue[s] = 1; claimed[bk] = 1; rdy[s] = 1;
               end else if (occ < DEPTH) begin
                  put[s] = 1; rdy[s] = 1; occ++;
               end
            end
         end
         // compare ready (R2 start, R4 buffered, R9 held off)
         for (int s = 0; s < NSRC; s++)
            chk(req_ready[s] == rdy[s], !rdy[s] ? "R9 ready" : (issue[s] ? "R2 ready" : "R4 ready"),
                int'(req_ready[s]), int'(rdy[s]));
         // compare every response lane (R2 timing and payload)
         for (int b = 0; b < NB; b++) begin
            bit ev;
            ev = (cyc == start_cyc[b] + BUSY - 1);
            chk(rsp_valid[b] == ev, "R2 rsp_valid", int'(rsp_valid[b]), int'(ev));
            if (ev && rsp_valid[b]) begin
               chk(int'(rsp_src[b]) == s_src[b], "R2 rsp_src", int'(rsp_src[b]), s_src[b]);
               chk(int'(rsp_tag[b*TW +: TW]) == s_tag[b], "R2 rsp_tag",
                   int'(rsp_tag[b*TW +: TW]), s_tag[b]);
            end
         end
         // commit the cycle
         if (pick >= 0) begin
            bk = q[pick].bank;
            start_cyc[bk] = cyc; s_src[bk] = q[pick].src; s_tag[bk] = q[pick].tag;
            q.delete(pick);
         end
         for (int s = 0; s < NSRC; s++) begin
            bk = int'(req_addr[s*AW +: AW]) % NB;
            if (issue[s]) begin
               start_cyc[bk] = cyc; s_src[bk] = s; s_tag[bk] = int'(req_tag[s*TW +: TW]);
            end
         end
         for (int s = 0; s < NSRC; s++)
            if (put[s]) q.push_back('{src: s, tag: int'(req_tag[s*TW +: TW]),
                                     bank: int'(req_addr[s*AW +: AW]) % NB});
         for (int s = 0; s < NSRC; s++) acc[s] = req_valid[s] && req_ready[s];
         cyc++;
      end
   end

   // ---------------- stimulus ----------------
   task automatic step(input bit v0, input int a0, input int t0,
                       input bit v1, input int a1, input int t1);
      @(posedge clk); #2;
      req_valid = {v1, v0};
      req_addr  = {AW'(a1), AW'(a0)};
      req_tag   = {TW'(t1), TW'(t0)};
   endtask

   task automatic finish_run();
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
   endtask

   initial begin
      #2_000_000;
      chk(0, "watchdog", 0, 1);
      finish_run();
   end

   initial begin
      int stride [NSRC];
      int addr [NSRC];
      int tg [NSRC];
      int sl [6] = '{1, 2, 3, 5, 7, 10};
      repeat (4) @(posedge clk);
      #2 rst_n = 1'b1;
      #1 chk(rsp_valid == '0, "R10 quiet after reset", int'(rsp_valid), 0);

      // --- directed: conflict, bypass, in-order drain ---
      step(1, 7, 1, 1, 12, 2);                 // both bank 2
      #1 chk(req_ready[0] == 1, "R8 low source starts", int'(req_ready[0]), 1);
      chk(req_ready[1] == 1, "R4 conflict buffered", int'(req_ready[1]), 1);
      step(1, 2, 3, 1, 13, 4);                 // bank 2 behind waiter, bank 3 free
      #1 chk(req_ready[0] == 1, "R7 same-bank buffered", int'(req_ready[0]), 1);
      chk(req_ready[1] == 1, "R5 bypass accepted", int'(req_ready[1]), 1);
      for (int k = 2; k <= 17; k++) begin
         bit e2, e3;
         step(0, 0, 0, 0, 0, 0);
         #1;
         e2 = (k == 5 || k == 11 || k == 17);
         e3 = (k == 6);
         chk(rsp_valid[2] == e2, "R3 R6 bank2 completion slot", int'(rsp_valid[2]), int'(e2));
         if (e2) chk(int'(rsp_tag[2*TW +: TW]) == ((k == 5) ? 1 : (k == 11) ? 2 : 3),
                     "R6 drain order tag", int'(rsp_tag[2*TW +: TW]),
                     (k == 5) ? 1 : (k == 11) ? 2 : 3);
         chk(rsp_valid[3] == e3, "R1 R5 bank3 lane", int'(rsp_valid[3]), int'(e3));
         if (e3) chk(int'(rsp_src[3]) == 1, "R1 bank3 source", int'(rsp_src[3]), 1);
      end
      repeat (3) step(0, 0, 0, 0, 0, 0);

      // --- directed: fill the buffer and hit backpressure ---
      step(1, 0, 1, 1, 5, 2);
      step(1, 10, 3, 1, 15, 4);
      step(1, 20, 5, 1, 25, 6);
      #1 chk(req_ready[0] == 1, "R8 last slot to low source", int'(req_ready[0]), 1);
      chk(req_ready[1] == 0, "R9 full buffer holds off", int'(req_ready[1]), 0);
      step(0, 0, 0, 1, 25, 6);
      #1 chk(req_ready[1] == 0, "R9 still full", int'(req_ready[1]), 0);
      repeat (40) step(0, 0, 0, 0, 0, 0);

      // --- strided random traffic against the model ---
      for (int s = 0; s < NSRC; s++) begin addr[s] = s * 3; tg[s] = 0; stride[s] = 1; end
      for (int c = 0; c < 4000; c++) begin
         if (c % 250 == 0)
            for (int s = 0; s < NSRC; s++) stride[s] = sl[$urandom % 6];
         @(posedge clk); #2;
         for (int s = 0; s < NSRC; s++) begin
            if (!req_valid[s] || acc[s]) begin
               req_valid[s] = (($urandom % 4) != 0);
               addr[s] = (addr[s] + stride[s]) % (1 << AW);
               tg[s] = (tg[s] + 1) % (1 << TW);
               req_addr[s*AW +: AW] = AW'(addr[s]);
               req_tag[s*TW +: TW]  = TW'(tg[s]);
            end
         end
      end
      repeat (20) step(0, 0, 0, 0, 0, 0);
      finish_run();
   end
endmodule